// File: doc/BRIEF.md
# Programmable Memory and Peripheral Chip-Select Decoder

This block watches a 20-bit bus address and a memory/I-O cycle flag. From them it produces active-low chip selects for three regions. The first is a low-memory region that starts at address zero. The second is a user-placed midrange memory block, divided into four equal parts. The third is a peripheral block of 256-byte windows, which can sit in memory space or in the 64 KB I/O space. It also reports the wait-state count and the ready-ignore flag that belong to the region being selected.

Four 16-bit configuration words program the block through a small write/read port: low, midrange, peripheral and auxiliary. No select group can assert after reset until its configuration words have been touched by a read or a write. Two of the peripheral pins can be switched to carry address bits instead of acting as selects. An optional register stage on the incoming address models the later arrival of a latched address.

Top module: `cs_unit`

## Requirements
- R1: After reset, every select output is high, `wait_cnt` is 0, `rdy_ign` is 0 and all four configuration words read back as 0.
- R2: The low select (`low_cs_n`) is enabled by any read or write of word 0. It asserts on memory cycles with an address below 8 KB << s, where s = word0[2:0] and values above 6 count as 6. Its wait count is word0[5:4] and its ready-ignore flag is word0[6].
- R3: The midrange selects are enabled only after both word 1 and word 3 have been read or written, in either order.
- R4: The midrange block size is 8 KB << m, where m = word3[2:0] and values above 6 count as 6. The base address is word1[15:9] × 8 KB, rounded down to a multiple of the block size. The block is split into four equal quarters, and `mid_cs_n[i]` selects quarter i. Memory cycles only. The wait count is word1[5:4] and the ready-ignore flag is word1[6].
- R5: Low has the highest priority, then peripheral, then midrange. At most one select asserts for any cycle.
- R6: The peripheral selects are enabled only after both word 2 and word 3 have been accessed. The base is word2[15:7] × 2 KB. Window n (0..6) covers base + n×256 to base + n×256 + 255 and drives `peri_cs_n[n]`. Window 4 and offsets from 1792 to 2047 select nothing, and `peri_cs_n[4]` is always high. The wait count is word2[5:4] and the ready-ignore flag is word2[6].
- R7: word3[3] chooses the peripheral space. With 1, only I/O cycles decode; with 0, only memory cycles decode.
- R8: When word3[4] is 1, `peri_cs_n[6]` carries address bit 1 and `peri_cs_n[5]` carries address bit 2 of the decoded cycle, and windows 5 and 6 select nothing.
- R9: When no select asserts, `wait_cnt` is 0 and `rdy_ign` is 0.
- R10: With `bus_cyc` low, no select asserts. Outputs follow the bus inputs 1 + ADDR_STAGE clock edges later.
- R11: A read of word k (`cfg_sel` = k) returns its stored value on `cfg_rdata` at the next edge. A write stores all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Word select: 0 low, 1 midrange, 2 peripheral, 3 auxiliary |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data |
| bus_cyc | input | 1 | A bus cycle is active |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_addr | input | 20 | Bus address |
| low_cs_n | output | 1 | Low-memory select, active low |
| mid_cs_n | output | 4 | Midrange quarter selects, active low |
| peri_cs_n | output | 7 | Peripheral window selects (bit 4 unused, high), bits 6/5 may carry address |
| wait_cnt | output | 2 | Wait states of the selected region |
| rdy_ign | output | 1 | Ready-ignore flag of the selected region |

## Verification
With the default of no address stage, every select, `wait_cnt` and `rdy_ign` is due exactly one clock edge after the bus inputs are applied. The bench drives at a falling edge and compares at the next falling edge. Read data also appears one edge after the read strobe, so each read is compared one falling edge after it is issued. Enables take effect on the edge that registers the access, so the first bus probe that follows an access already sees the group enabled.

// File: rtl/cs_unit_pkg.sv
package cs_unit_pkg;
  localparam int N_CFG      = 4;
  localparam int CFG_LOW    = 0;
  localparam int CFG_MID    = 1;
  localparam int CFG_PERI   = 2;
  localparam int CFG_AUX    = 3;
  localparam int N_MID      = 4;
  localparam int N_PERI     = 7;
  localparam int PERI_HOLE  = 4;
  localparam int PIN_A2_IDX = 5;
  localparam int PIN_A1_IDX = 6;
  localparam int RDY_BIT    = 6;
  localparam int WAIT_LSB   = 4;
  localparam int AUX_IO_BIT = 3;
  localparam int AUX_PIN_BIT = 4;

  typedef struct packed {
    logic              low;
    logic [N_MID-1:0]  mid;
    logic [N_PERI-1:0] peri;
    logic [1:0]        waits;
    logic              rdy_ign;
  } dec_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs #(
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  localparam int SEL_W = $clog2(N_REG)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [SEL_W-1:0]               sel,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [N_REG-1:0][DATA_W-1:0]   regs_o,
  output logic                           low_en,
  output logic                           mid_en,
  output logic                           peri_en
);
  import cs_unit_pkg::*;

  logic [N_REG-1:0][DATA_W-1:0] regs_q;
  logic [N_REG-1:0]             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
      seen_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr) regs_q[sel] <= wdata;
      if (wr || rd) seen_q[sel] <= 1'b1;
      if (rd) rdata <= regs_q[sel];
    end
  end

  assign regs_o  = regs_q;
  assign low_en  = seen_q[CFG_LOW];
  assign mid_en  = seen_q[CFG_MID]  & seen_q[CFG_AUX];
  assign peri_en = seen_q[CFG_PERI] & seen_q[CFG_AUX];

  a_r2_low_en_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(low_en) |-> $past((wr || rd) && sel == SEL_W'(CFG_LOW)));

  a_r3_mid_en_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mid_en) |-> $past((wr || rd) &&
      (sel == SEL_W'(CFG_MID) || sel == SEL_W'(CFG_AUX))));

  a_r6_peri_en_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(peri_en) |-> $past((wr || rd) &&
      (sel == SEL_W'(CFG_PERI) || sel == SEL_W'(CFG_AUX))));
endmodule

// File: rtl/cs_addr_stage.sv
module cs_addr_stage #(
  parameter int ADDR_W = 20,
  parameter int STAGES = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_i,
  input  logic              io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cyc_o,
  output logic              io_o,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (STAGES == 0) begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign cyc_o  = cyc_i;
      assign io_o   = io_i;
      assign addr_o = addr_i;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          cyc_o  <= 1'b0;
          io_o   <= 1'b0;
          addr_o <= '0;
        end else begin
          cyc_o  <= cyc_i;
          io_o   <= io_i;
          addr_o <= addr_i;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int MIN_BLK_LOG2  = 13,
  parameter int MAX_SIZE_CODE = 6,
  parameter int PERI_WIN_LOG2 = 8
) (
  input  logic                cyc,
  input  logic                io,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   low_reg,
  input  logic [DATA_W-1:0]   mid_reg,
  input  logic [DATA_W-1:0]   peri_reg,
  input  logic [DATA_W-1:0]   aux_reg,
  input  logic                low_en,
  input  logic                mid_en,
  input  logic                peri_en,
  output cs_unit_pkg::dec_t   dec_o
);
  import cs_unit_pkg::*;

  localparam int MB_W     = ADDR_W - MIN_BLK_LOG2;
  localparam int PB_ALIGN = PERI_WIN_LOG2 + 3;
  localparam int PB_W     = ADDR_W - PB_ALIGN;

  function automatic int sat_code(input logic [2:0] c);
    return (int'(c) > MAX_SIZE_CODE) ? MAX_SIZE_CODE : int'(c);
  endfunction

  int                lk, mk;
  logic [ADDR_W-1:0] mid_base, mid_mask, mid_shift;
  logic [1:0]        mid_idx;
  logic [2:0]        win;
  logic              low_hit, mid_hit, peri_hit, win_ok, pin_mode, peri_io;

  always_comb begin
    lk       = MIN_BLK_LOG2 + sat_code(low_reg[2:0]);
    mk       = MIN_BLK_LOG2 + sat_code(aux_reg[2:0]);
    pin_mode = aux_reg[AUX_PIN_BIT];
    peri_io  = aux_reg[AUX_IO_BIT];

    low_hit  = cyc && !io && low_en && ((addr >> lk) == '0);

    mid_base  = {mid_reg[DATA_W-1 -: MB_W], {MIN_BLK_LOG2{1'b0}}};
    mid_mask  = {ADDR_W{1'b1}} << mk;
    mid_hit   = cyc && !io && mid_en && (((addr ^ mid_base) & mid_mask) == '0);
    mid_shift = addr >> (mk - 2);
    mid_idx   = mid_shift[1:0];

    win      = addr[PB_ALIGN-1:PERI_WIN_LOG2];
    win_ok   = (win != 3'd7) && (win != 3'(PERI_HOLE)) &&
               !(pin_mode && (win == 3'(PIN_A2_IDX) || win == 3'(PIN_A1_IDX)));
    peri_hit = cyc && peri_en && (io == peri_io) && win_ok &&
               (addr[ADDR_W-1:PB_ALIGN] == peri_reg[DATA_W-1 -: PB_W]);

    dec_o = '0;
    if (low_hit) begin
      dec_o.low     = 1'b1;
      dec_o.waits   = low_reg[WAIT_LSB +: 2];
      dec_o.rdy_ign = low_reg[RDY_BIT];
    end else if (peri_hit) begin
      dec_o.peri[win] = 1'b1;
      dec_o.waits     = peri_reg[WAIT_LSB +: 2];
      dec_o.rdy_ign   = peri_reg[RDY_BIT];
    end else if (mid_hit) begin
      dec_o.mid[mid_idx] = 1'b1;
      dec_o.waits        = mid_reg[WAIT_LSB +: 2];
      dec_o.rdy_ign      = mid_reg[RDY_BIT];
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{low_reg[DATA_W-1:RDY_BIT+1], low_reg[3],
                             mid_reg[DATA_W-MB_W-1:RDY_BIT+1], mid_reg[3:0],
                             peri_reg[3:0], aux_reg[DATA_W-1:AUX_PIN_BIT+1]};

  always_comb begin
    a_r5_one_region: assert ($onehot0({low_hit, dec_o.mid, dec_o.peri}) || rst_free());
  end

  function automatic logic rst_free();
    return 1'b0;
  endfunction
endmodule

// File: rtl/cs_unit.sv
module cs_unit #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int MIN_BLK_LOG2  = 13,
  parameter int MAX_SIZE_CODE = 6,
  parameter int PERI_WIN_LOG2 = 8,
  parameter int ADDR_STAGE    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              bus_cyc,
  input  logic              bus_io,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              low_cs_n,
  output logic [3:0]        mid_cs_n,
  output logic [6:0]        peri_cs_n,
  output logic [1:0]        wait_cnt,
  output logic              rdy_ign
);
  import cs_unit_pkg::*;

  logic [N_CFG-1:0][DATA_W-1:0] cfg_regs;
  logic low_en, mid_en, peri_en;

  cs_cfg_regs #(.DATA_W(DATA_W), .N_REG(N_CFG)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_o(cfg_regs),
    .low_en(low_en), .mid_en(mid_en), .peri_en(peri_en)
  );

  logic              stg_cyc, stg_io;
  logic [ADDR_W-1:0] stg_addr;

  cs_addr_stage #(.ADDR_W(ADDR_W), .STAGES(ADDR_STAGE)) u_stage (
    .clk(clk), .rst(rst), .cyc_i(bus_cyc), .io_i(bus_io), .addr_i(bus_addr),
    .cyc_o(stg_cyc), .io_o(stg_io), .addr_o(stg_addr)
  );

  dec_t dec_c, dec_q;

  cs_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_BLK_LOG2(MIN_BLK_LOG2),
    .MAX_SIZE_CODE(MAX_SIZE_CODE), .PERI_WIN_LOG2(PERI_WIN_LOG2)
  ) u_dec (
    .cyc(stg_cyc), .io(stg_io), .addr(stg_addr),
    .low_reg(cfg_regs[CFG_LOW]), .mid_reg(cfg_regs[CFG_MID]),
    .peri_reg(cfg_regs[CFG_PERI]), .aux_reg(cfg_regs[CFG_AUX]),
    .low_en(low_en), .mid_en(mid_en), .peri_en(peri_en), .dec_o(dec_c)
  );

  logic       pin_mode_q;
  logic [1:0] abits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q      <= '0;
      pin_mode_q <= 1'b0;
      abits_q    <= '0;
    end else begin
      dec_q      <= dec_c;
      pin_mode_q <= cfg_regs[CFG_AUX][AUX_PIN_BIT];
      abits_q    <= stg_addr[2:1];
    end
  end

  assign low_cs_n = ~dec_q.low;
  assign mid_cs_n = ~dec_q.mid;
  assign wait_cnt = dec_q.waits;
  assign rdy_ign  = dec_q.rdy_ign;

  generate
    for (genvar g = 0; g < N_PERI; g++) begin : g_peri
      if (g == PERI_HOLE) begin : g_hole
        assign peri_cs_n[g] = 1'b1;
      end else if (g == PIN_A1_IDX) begin : g_a1
        assign peri_cs_n[g] = pin_mode_q ? abits_q[0] : ~dec_q.peri[g];
      end else if (g == PIN_A2_IDX) begin : g_a2
        assign peri_cs_n[g] = pin_mode_q ? abits_q[1] : ~dec_q.peri[g];
      end else begin : g_sel
        assign peri_cs_n[g] = ~dec_q.peri[g];
      end
    end
  endgenerate

  logic [1:0] pin_act;
  assign pin_act = pin_mode_q ? 2'b00 : ~peri_cs_n[6:5];

  a_r5_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~low_cs_n, ~mid_cs_n, pin_act, ~peri_cs_n[4:0]}));

  a_r6_hole_unused: assert property (@(posedge clk) disable iff (rst)
    !dec_q.peri[PERI_HOLE]);

  a_r6_peri_gated: assert property (@(posedge clk) disable iff (rst)
    !peri_en |=> (&peri_cs_n[3:0]));

  a_r3_mid_gated: assert property (@(posedge clk) disable iff (rst)
    !mid_en |=> (&mid_cs_n));

  a_r2_low_gated: assert property (@(posedge clk) disable iff (rst)
    !low_en |=> low_cs_n);

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !stg_cyc |=> (low_cs_n && (&mid_cs_n) && wait_cnt == 2'd0 && !rdy_ign));

  a_r8_addr_pins: assert property (@(posedge clk) disable iff (rst)
    cfg_regs[CFG_AUX][AUX_PIN_BIT] |=>
      (peri_cs_n[PIN_A1_IDX] == $past(stg_addr[1]) &&
       peri_cs_n[PIN_A2_IDX] == $past(stg_addr[2])));

  a_r9_quiet_status: assert property (@(posedge clk) disable iff (rst)
    (low_cs_n && (&mid_cs_n) && (&peri_cs_n[3:0]) &&
     (pin_mode_q || (&peri_cs_n[6:5]))) |-> (wait_cnt == 2'd0 && !rdy_ign));
endmodule

// File: tb/cs_unit_tb_top.sv
module cs_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        bus_cyc, bus_io;
  logic [19:0] bus_addr;
  logic        low_cs_n, rdy_ign;
  logic [3:0]  mid_cs_n;
  logic [6:0]  peri_cs_n;
  logic [1:0]  wait_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cs_unit dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_cyc(bus_cyc),
    .bus_io(bus_io), .bus_addr(bus_addr), .low_cs_n(low_cs_n),
    .mid_cs_n(mid_cs_n), .peri_cs_n(peri_cs_n), .wait_cnt(wait_cnt),
    .rdy_ign(rdy_ign)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] m_word [4];
  bit          m_seen [4];

  task automatic check_val(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int k, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = 2'(k); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_word[k] = d; m_seen[k] = 1'b1;
  endtask

  task automatic cfg_read(input int k, input string req);
    cfg_rd = 1'b1; cfg_sel = 2'(k);
    @(negedge clk);
    cfg_rd = 1'b0;
    m_seen[k] = 1'b1;
    check_val(req, $sformatf("readback word %0d", k), 32'(cfg_rdata), 32'(m_word[k]));
  endtask

  task automatic model(input bit cyc, input bit io, input int a,
                       output logic [11:0] exp_n, output logic [2:0] exp_st,
                       output string tag);
    int s, m, lsz, blk, base, pb, off, n;
    bit pin;
    logic [11:0] act;
    act = '0; exp_st = '0; tag = "R10";
    pin = m_word[3][4];
    s = int'(m_word[0][2:0]); if (s > 6) s = 6;
    m = int'(m_word[3][2:0]); if (m > 6) m = 6;
    lsz  = 8192 << s;
    blk  = 8192 << m;
    base = ((int'(m_word[1][15:9]) * 8192) / blk) * blk;
    pb   = int'(m_word[2][15:7]) * 2048;
    off  = a - pb;
    n    = (off >= 0) ? off / 256 : 0;
    if (cyc) begin
      if (!io && m_seen[0] && a < lsz) begin
        act[11] = 1'b1; exp_st = {m_word[0][5:4], m_word[0][6]}; tag = "R2";
      end else if (m_seen[2] && m_seen[3] && (io == m_word[3][3]) &&
                   off >= 0 && off < 1792 && n != 4 &&
                   !(pin && (n == 5 || n == 6))) begin
        act[n] = 1'b1; exp_st = {m_word[2][5:4], m_word[2][6]};
        tag = io ? "R7" : "R6";
      end else if (!io && m_seen[1] && m_seen[3] && a >= base && a < base + blk) begin
        act[7 + (a - base) / (blk / 4)] = 1'b1;
        exp_st = {m_word[1][5:4], m_word[1][6]}; tag = "R4";
      end else begin
        tag = "R9";
      end
    end
    exp_n = ~act;
    if (pin) begin
      exp_n[6] = a[1];
      exp_n[5] = a[2];
      tag = {tag, "/R8"};
    end
  endtask

  task automatic probe(input bit cyc, input bit io, input int a, input string req);
    logic [11:0] exp_n;
    logic [2:0]  exp_st;
    string       tag;
    bus_cyc = cyc; bus_io = io; bus_addr = a[19:0];
    model(cyc, io, a, exp_n, exp_st, tag);
    @(negedge clk);
    check_val({req, "/", tag}, $sformatf("selects at %05h io=%0d cyc=%0d", a, io, cyc),
              32'({low_cs_n, mid_cs_n, peri_cs_n}), 32'(exp_n));
    check_val({req, "/R9"}, $sformatf("wait/ready at %05h", a),
              32'({wait_cnt, rdy_ign}), 32'(exp_st));
  endtask

  task automatic sweep(input bit io, input int step, input int count, input string req);
    for (int i = 0; i < count; i++) begin
      int a;
      a = i * step + ((i * 37) % step);
      probe((i % 16) != 5, io, a, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_word[k] = '0; m_seen[k] = 1'b0; end
    rst = 1'b1; cfg_wr = 0; cfg_rd = 0; cfg_sel = 0; cfg_wdata = 0;
    bus_cyc = 0; bus_io = 0; bus_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check_val("R1", "selects after reset", 32'({low_cs_n, mid_cs_n, peri_cs_n}), 32'hFFF);
    check_val("R1", "status after reset", 32'({wait_cnt, rdy_ign}), 32'h0);
    check_val("R1", "read data after reset", 32'(cfg_rdata), 32'h0);
    probe(1, 0, 0, "R1");

    // R3/R6: one half of each pair accessed does not enable
    cfg_write(1, 16'h4060);
    probe(1, 0, 32'h40000, "R3");
    cfg_write(2, 16'h4090);
    probe(1, 0, 32'h40800, "R6");
    cfg_read(3, "R11");
    probe(1, 0, 32'h40800, "R6");
    probe(1, 0, 32'h40000, "R3");

    // Config A: 32 KB midrange, peripheral in memory overlapping it
    cfg_write(3, 16'h0002);
    cfg_read(3, "R11");
    cfg_read(1, "R11");
    cfg_read(2, "R11");
    probe(1, 0, 32'h00100, "R2");
    sweep(0, 256, 4096, "R5");
    sweep(1, 1024, 64, "R7");

    // R2: read alone enables the low select
    cfg_read(0, "R2");
    probe(1, 0, 32'h00100, "R2");
    probe(1, 0, 32'h02000, "R2");
    cfg_write(0, 16'h0033);
    cfg_read(0, "R11");
    sweep(0, 256, 4096, "R4");

    // Config B: saturated 512 KB midrange, peripheral in I/O, address pins
    cfg_write(3, 16'h001F);
    cfg_write(2, 16'h00C0);
    sweep(0, 256, 4096, "R4");
    sweep(1, 16, 4096, "R7");
    probe(0, 1, 32'h00D06, "R10");

    // Config C: saturated low size, high midrange with peripheral on top
    cfg_write(0, 16'h0047);
    cfg_write(1, 16'hF210);
    cfg_write(3, 16'h0000);
    cfg_write(2, 16'hF220);
    cfg_read(1, "R11");
    sweep(0, 256, 4096, "R6");
    sweep(1, 1024, 64, "R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule